// File: doc/BRIEF.md
# Three-wire strobed configuration port

This block is the slave end of a three-wire serial link (serial clock, serial data, active-low strobe) that loads a transceiver control section with its settings. A transfer is 24 bits long. The first 23 bits carry the payload, most significant bit first. The 24th and final bit picks which of two 23-bit configuration words receives that payload. The block shifts bits in on rising serial-clock edges while the strobe is low. It commits the frame to the chosen word when the strobe goes back high, but only if exactly 24 edges were counted. A frame of any other length is thrown away and raises a sticky error flag.

All serial and enable pins are brought into a faster system clock domain through synchronisers. Edges are then found by comparing each synchronised value with the one from the cycle before, so every register update is synchronous to the system clock. Each successful commit gives a one-cycle pulse together with the address of the word that was written. The block also produces the enable outputs for the control section. The control section is on while the strobe is low or while the active-low enable pin is low. The receive and transmit enables are each driven either by their own active-low pin or by a bit of word A, and both are gated by the control enable.

Top module: `tw_cfg_port`

## Requirements
- R1: A frame of exactly 24 rising serial-clock edges stores its first 23 bits in the addressed word. The first bit shifted in becomes bit 22 and the 23rd bit becomes bit 0.
- R2: The 24th bit is the word address. A value of 0 writes word A and a value of 1 writes word B. The word that is not addressed keeps its value.
- R3: Neither word changes while a frame is being shifted in. The write happens only after the strobe returns high.
- R4: Serial-clock edges that arrive while the strobe is high do not shift or count. A 24-bit frame sent after such edges still commits correctly and raises no error.
- R5: When the strobe rises after a count of rising clock edges other than 24 (for example 0, 23 or 25), both words keep their values, no update pulse is given, and the frame-error output goes to 1. It stays at 1 until reset.
- R6: Each committed frame produces exactly one single-cycle pulse on `upd_pulse`. At that moment `upd_addr` shows the written word: 0 for A, 1 for B.
- R7: `ctrl_on` is 1 while the strobe is low or `en_n` is low, and 0 when both are high. The change appears a few system cycles after the pins change.
- R8: `rx_on` is `ctrl_on` AND (`rx_en_n` low OR word A bit 0 set). `tx_on` is `ctrl_on` AND (`tx_en_n` low OR word A bit 1 set).
- R9: After reset, both words hold their parameter reset values (zero by default), and `frame_err`, `upd_pulse`, `ctrl_on`, `rx_on` and `tx_on` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_stb_n | input | 1 | Active-low strobe; a rising edge commits the frame |
| en_n | input | 1 | Active-low control-section enable pin |
| rx_en_n | input | 1 | Active-low hard-wired receive enable |
| tx_en_n | input | 1 | Active-low hard-wired transmit enable |
| word_a | output | DATA_W | Configuration word A |
| word_b | output | DATA_W | Configuration word B |
| upd_pulse | output | 1 | One-cycle pulse when a word is written |
| upd_addr | output | 1 | Address of the word that was last written |
| frame_err | output | 1 | Sticky flag set by a frame of the wrong length |
| ctrl_on | output | 1 | Control section enable |
| rx_on | output | 1 | Receiver enable |
| tx_on | output | 1 | Transmitter enable |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each serial-clock level and each data value must be held for several system cycles, so that the synchroniser sees every edge once. They also assume that the strobe stays high for at least two cycles between frames, so that two commits can never fall on neighbouring cycles. The bench keeps every serial half-period at 40 ns, which is ten system cycles. It holds the data stable for the full clock period around each rising edge and separates frames by well over a hundred nanoseconds of strobe-high time.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  typedef enum logic {
    WORD_A = 1'b0,
    WORD_B = 1'b1
  } word_sel_e;

  // positions of the raw pins inside the synchroniser vector
  localparam int PIN_CK  = 0;
  localparam int PIN_DAT = 1;
  localparam int PIN_STB = 2;
  localparam int PIN_EN  = 3;
  localparam int PIN_RX  = 4;
  localparam int PIN_TX  = 5;
  localparam int PIN_NUM = 6;

  // idle levels: clock and data low, all active-low pins high
  localparam logic [PIN_NUM-1:0] PIN_IDLE = 6'b111100;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb chain_d[s] = d;
    end else begin : g_next
      always_comb chain_d[s] = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= RST_VAL;
      else        chain_q[s] <= chain_d[s];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int FRAME_W = 24,
  parameter int CNT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               clr,
  input  logic               din,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   count
);
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sr_d = {sr_q[FRAME_W-2:0], din};
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame = sr_q;
  assign count = cnt_q;
endmodule

// File: rtl/tw_word_bank.sv
module tw_word_bank
  import tw_cfg_pkg::*;
#(
  parameter int DATA_W = 23,
  parameter logic [DATA_W-1:0] A_RST = '0,
  parameter logic [DATA_W-1:0] B_RST = '0,
  localparam int FRAME_W = DATA_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic               len_ok,
  input  logic [FRAME_W-1:0] frame,
  output logic [DATA_W-1:0]  word_a,
  output logic [DATA_W-1:0]  word_b,
  output logic               upd_pulse,
  output logic               upd_addr,
  output logic               frame_err
);
  logic [DATA_W-1:0] wa_q, wa_d, wb_q, wb_d;
  logic              pls_q, pls_d, adr_q, adr_d, err_q, err_d;
  logic              wr_ok;
  word_sel_e         sel;

  assign sel   = word_sel_e'(frame[0]);
  assign wr_ok = commit & len_ok;

  always_comb begin
    wa_d  = wa_q;
    wb_d  = wb_q;
    adr_d = adr_q;
    pls_d = wr_ok;
    err_d = err_q | (commit & ~len_ok);
    if (wr_ok) begin
      adr_d = sel;
      if (sel == WORD_A) wa_d = frame[FRAME_W-1:1];
      else               wb_d = frame[FRAME_W-1:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q  <= A_RST;
      wb_q  <= B_RST;
      pls_q <= 1'b0;
      adr_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      wa_q  <= wa_d;
      wb_q  <= wb_d;
      pls_q <= pls_d;
      adr_q <= adr_d;
      err_q <= err_d;
    end
  end

  assign word_a    = wa_q;
  assign word_b    = wb_q;
  assign upd_pulse = pls_q;
  assign upd_addr  = adr_q;
  assign frame_err = err_q;
endmodule

// File: rtl/tw_cfg_port.sv
module tw_cfg_port
  import tw_cfg_pkg::*;
#(
  parameter int DATA_W = 23,
  parameter logic [DATA_W-1:0] A_RST = '0,
  parameter logic [DATA_W-1:0] B_RST = '0,
  parameter int RX_BIT = 0,
  parameter int TX_BIT = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_stb_n,
  input  logic              en_n,
  input  logic              rx_en_n,
  input  logic              tx_en_n,
  output logic [DATA_W-1:0] word_a,
  output logic [DATA_W-1:0] word_b,
  output logic              upd_pulse,
  output logic              upd_addr,
  output logic              frame_err,
  output logic              ctrl_on,
  output logic              rx_on,
  output logic              tx_on
);
  localparam int FRAME_W = DATA_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  logic [PIN_NUM-1:0] pin_raw, pin_syn;
  assign pin_raw = {tx_en_n, rx_en_n, en_n, ser_stb_n, ser_dat, ser_clk};

  tw_sync #(.W(PIN_NUM), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (pin_raw),
    .q     (pin_syn)
  );

  // edge detection on serial clock and strobe
  logic ck_prev_q, ck_prev_d, stb_prev_q, stb_prev_d;
  always_comb begin
    ck_prev_d  = pin_syn[PIN_CK];
    stb_prev_d = pin_syn[PIN_STB];
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ck_prev_q  <= 1'b0;
      stb_prev_q <= 1'b1;
    end else begin
      ck_prev_q  <= ck_prev_d;
      stb_prev_q <= stb_prev_d;
    end
  end

  logic ck_rise, stb_rise, stb_low, shift_en;
  assign ck_rise  = pin_syn[PIN_CK] & ~ck_prev_q;
  assign stb_rise = pin_syn[PIN_STB] & ~stb_prev_q;
  assign stb_low  = ~pin_syn[PIN_STB];
  assign shift_en = ck_rise & stb_low;

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   count;
  logic               len_ok;

  tw_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i),
    .shift_en (shift_en),
    .clr      (~stb_low),
    .din      (pin_syn[PIN_DAT]),
    .frame    (frame),
    .count    (count)
  );

  assign len_ok = (count == CNT_W'(FRAME_W));

  tw_word_bank #(.DATA_W(DATA_W), .A_RST(A_RST), .B_RST(B_RST)) u_bank (
    .clk       (clk),
    .rst_n     (rst_i),
    .commit    (stb_rise),
    .len_ok    (len_ok),
    .frame     (frame),
    .word_a    (word_a),
    .word_b    (word_b),
    .upd_pulse (upd_pulse),
    .upd_addr  (upd_addr),
    .frame_err (frame_err)
  );

  // enable merging
  always_comb begin
    ctrl_on = stb_low | ~pin_syn[PIN_EN];
    rx_on   = ctrl_on & (~pin_syn[PIN_RX] | word_a[RX_BIT]);
    tx_on   = ctrl_on & (~pin_syn[PIN_TX] | word_a[TX_BIT]);
  end
endmodule

// File: rtl/tw_cfg_port_chk.sv
module tw_cfg_port_chk #(
  parameter int DATA_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] word_a,
  input logic [DATA_W-1:0] word_b,
  input logic              upd_pulse,
  input logic              upd_addr,
  input logic              frame_err
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R5

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !upd_pulse); // R5

  AST_A_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_a) |-> (upd_pulse && !upd_addr)); // R2

  AST_B_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_b) |-> (upd_pulse && upd_addr)); // R3
endmodule

bind tw_cfg_port tw_cfg_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_a    (word_a),
  .word_b    (word_b),
  .upd_pulse (upd_pulse),
  .upd_addr  (upd_addr),
  .frame_err (frame_err)
);

// File: tb/sim_tw_cfg_port.sv
`timescale 1ns/1ps
module sim_tw_cfg_port;
  localparam int DW = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb_n = 1'b1;
  logic en_n = 1'b1, rx_en_n = 1'b1, tx_en_n = 1'b1;
  logic [DW-1:0] word_a, word_b;
  logic upd_pulse, upd_addr, frame_err, ctrl_on, rx_on, tx_on;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic last_addr = 1'b0;
  logic [DW-1:0] exp_a = '0, exp_b = '0;

  always #2 clk = ~clk;

  tw_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_stb_n(ser_stb_n), .en_n(en_n), .rx_en_n(rx_en_n), .tx_en_n(tx_en_n),
    .word_a(word_a), .word_b(word_b), .upd_pulse(upd_pulse),
    .upd_addr(upd_addr), .frame_err(frame_err), .ctrl_on(ctrl_on),
    .rx_on(rx_on), .tx_on(tx_on)
  );

  always @(negedge clk) begin
    if (upd_pulse) begin
      pulses++;
      last_addr <= upd_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input int n, input logic [31:0] bits);
    ser_stb_n = 1'b0;
    #40;
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      #40 ser_clk = 1'b1;
      #40 ser_clk = 1'b0;
    end
    #40 ser_stb_n = 1'b1;
    #160;
  endtask

  task automatic t_reset();
    chk("R9 word_a", 32'(word_a), 32'h0);
    chk("R9 word_b", 32'(word_b), 32'h0);
    chk("R9 frame_err", 32'(frame_err), 32'h0);
    chk("R9 upd_pulse", 32'(upd_pulse), 32'h0);
    chk("R9 ctrl_on", 32'(ctrl_on), 32'h0);
    chk("R9 rx/tx", 32'({rx_on, tx_on}), 32'h0);
  endtask

  task automatic t_write(input string req, input logic [DW-1:0] val, input logic addr);
    int p0;
    p0 = pulses;
    // R3: check mid-frame that nothing is written yet
    ser_stb_n = 1'b0;
    #40;
    for (int i = DW; i >= 0; i--) begin
      ser_dat = (i == 0) ? addr : val[i-1];
      #40 ser_clk = 1'b1;
      #40 ser_clk = 1'b0;
    end
    #80;
    chk("R3 word_a unchanged before strobe rise", 32'(word_a), 32'(exp_a));
    chk("R3 word_b unchanged before strobe rise", 32'(word_b), 32'(exp_b));
    ser_stb_n = 1'b1;
    #160;
    if (addr) exp_b = val; else exp_a = val;
    chk({req, " word_a"}, 32'(word_a), 32'(exp_a));
    chk({req, " word_b"}, 32'(word_b), 32'(exp_b));
    chk("R6 one pulse", 32'(pulses - p0), 32'd1);
    chk("R6 pulse address", 32'(last_addr), 32'(addr));
  endtask

  task automatic t_idle_clocks();
    ser_dat = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #40 ser_clk = 1'b1;
      #40 ser_clk = 1'b0;
    end
    #40;
    t_write("R4 after idle clocks", 23'h2AAAAA, 1'b1);
    chk("R4 no error", 32'(frame_err), 32'h0);
  endtask

  task automatic t_enables();
    #80;
    chk("R7 idle ctrl_on", 32'(ctrl_on), 32'h0);
    en_n = 1'b0; #60;
    chk("R7 en_n low ctrl_on", 32'(ctrl_on), 32'h1);
    chk("R8 rx from reg bit0", 32'(rx_on), 32'h1);
    chk("R8 tx off", 32'(tx_on), 32'h0);
    tx_en_n = 1'b0; #60;
    chk("R8 tx pin", 32'(tx_on), 32'h1);
    en_n = 1'b1; #60;
    chk("R7 both high", 32'(ctrl_on), 32'h0);
    chk("R8 gated off", 32'({rx_on, tx_on}), 32'h0);
    ser_stb_n = 1'b0; #60;
    chk("R7 strobe low ctrl_on", 32'(ctrl_on), 32'h1);
    ser_stb_n = 1'b1; tx_en_n = 1'b1; #200;
  endtask

  task automatic t_bad(input string req, input int n);
    int p0;
    p0 = pulses;
    send_bits(n, 32'h1FFFFFF);
    chk({req, " word_a kept"}, 32'(word_a), 32'(exp_a));
    chk({req, " word_b kept"}, 32'(word_b), 32'(exp_b));
    chk({req, " no pulse"}, 32'(pulses - p0), 32'd0);
    chk({req, " frame_err"}, 32'(frame_err), 32'h1);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #21 rst_n = 1'b1;
    #40;
    t_reset();
    t_write("R1 R2 word A", 23'h5A3C96, 1'b0);
    t_write("R1 R2 word B", 23'h7FFFFE, 1'b1);
    t_idle_clocks();
    t_write("R1 word A bit0", 23'h000001, 1'b0);
    t_enables();
    t_bad("R5 23 bits", 23);
    t_bad("R5 25 bits", 25);
    t_bad("R5 0 bits", 0);
    t_write("R5 sticky then good", 23'h123456, 1'b1);
    chk("R5 error still set", 32'(frame_err), 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule